// File: doc/BRIEF.md
# FIFO Depth-Expansion Token Controller

This block is one node of a deeper FIFO built from several identical FIFO nodes wired in a ring. Each node owns a small local store and two tokens. The write token marks the node that takes incoming words. The read token marks the node that supplies outgoing words. The node that holds the write token accepts writes until it fills its last physical location. In that same cycle it drives a one-cycle low pulse on its write hand-off output and so passes the token to the next node. Reads move through a separate ring in the same way. The depth of the whole chain is the sum of the node depths.

All nodes share one clock, the write enable, the write data and the read enable. Each node's hand-off outputs feed the hand-off inputs of the next node, and the last node feeds the first. The head of the chain is marked by driving its head-select input low; every other node drives it high.

The levels seen on the two hand-off inputs during reset choose the operating mode. When both inputs are high, the node runs chained. Any other setting makes the node a stand-alone FIFO. In that case the node always owns both tokens, and its write hand-off output reports half-full instead.

Top module: `chain_fifo_node`

## Requirements
- R1: After reset all outputs are idle: `wr_xo_n`=1, `rd_xo_n`=1, `empty`=1, `full`=0 and `rd_fire`=0. In chained mode only the node with `head_n`=0 holds the write and read tokens.
- R2: The mode is sampled while `rst` is high. The node is chained when `wr_xi_n`=1 and `rd_xi_n`=1, and stand-alone otherwise. A stand-alone node owns both tokens permanently.
- R3: A write is accepted on a rising edge when `wr_en`=1, the node holds the write token and `full`=0. Accepted words are stored in arrival order.
- R4: A node that does not hold the write (read) token ignores `wr_en` (`rd_en`). Its `empty` and `full` outputs and its read data stay unchanged.
- R5: An accepted write into the last local location (index DEPTH-1) drives `wr_xo_n` low during that same cycle. The node drops its write token at that edge.
- R6: A node takes the write (read) token at the rising edge where it samples `wr_xi_n` (`rd_xi_n`) low in chained mode. Taking the token has priority over passing it, so a ring of one node keeps its tokens.
- R7: A read is accepted when `rd_en`=1, the node holds the read token and `empty`=0. In the cycle after that edge, `rd_data` holds the oldest stored word and `rd_fire` is 1 for exactly one cycle.
- R8: An accepted read of the last local location drives `rd_xo_n` low during that same cycle. The node drops its read token at that edge.
- R9: `full`=1 when the node holds DEPTH words and `empty`=1 when it holds none. A write to a full node and a read from an empty node are dropped.
- R10: In stand-alone mode, `wr_xo_n` is 0 exactly when the stored count is at least DEPTH/2, and `rd_xo_n` stays 1.
- R11: A ring of N chained nodes holds N*DEPTH words. The tokens wrap from the last node back to the head, and words leave the ring in the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by write and read sides |
| rst | input | 1 | Synchronous active-high reset; mode sampled while high |
| head_n | input | 1 | Low marks the head node of the chain |
| wr_xi_n | input | 1 | Write token hand-off in, active-low pulse |
| rd_xi_n | input | 1 | Read token hand-off in, active-low pulse |
| wr_xo_n | output | 1 | Write token hand-off out (chained) or active-low half-full (stand-alone) |
| rd_xo_n | output | 1 | Read token hand-off out, active-low pulse |
| wr_en | input | 1 | Write request |
| wr_data | input | W | Write word |
| rd_en | input | 1 | Read request |
| rd_data | output | W | Last word read from this node |
| rd_fire | output | 1 | One-cycle strobe: `rd_data` was loaded by this node |
| full | output | 1 | Local store holds DEPTH words |
| empty | output | 1 | Local store holds no words |

## Verification
The bench builds its nodes with DEPTH=4 and W=8. It wires three chained nodes into a ring and adds one stand-alone node. With a depth of four, every hand-off, the wrap from the last node back to the head and the full-ring condition at twelve words are reached within a few dozen cycles. The stand-alone node's half-full threshold of two words and its full point are reached with the same small depth. A monitor checks, for every delivered word, both its value and which node should supply it, so a token that moves at the wrong time shows up as a wrong source.

// File: rtl/chain_fifo_pkg.sv
package chain_fifo_pkg;

    typedef enum logic {
        MODE_SOLO  = 1'b0,
        MODE_CHAIN = 1'b1
    } node_mode_e;

    // index of each token in the per-token arrays
    localparam int TOK_WR = 0;
    localparam int TOK_RD = 1;
    localparam int TOK_N  = 2;

    typedef struct packed {
        logic wr;
        logic rd;
    } side_t;

    function automatic node_mode_e decode_mode(logic wr_in_n, logic rd_in_n);
        return (wr_in_n && rd_in_n) ? MODE_CHAIN : MODE_SOLO;
    endfunction

    function automatic int unsigned ptr_step(int unsigned p, int unsigned depth);
        return (p == depth - 1) ? 0 : p + 1;
    endfunction

endpackage

// File: rtl/chain_fifo_mode.sv
module chain_fifo_mode
    import chain_fifo_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_xi_n,
    input  logic       rd_xi_n,
    output node_mode_e mode
);
    node_mode_e mode_q;

    // sampled on every reset cycle, frozen afterwards
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= decode_mode(wr_xi_n, rd_xi_n);
        end
    end

    assign mode = mode_q;
endmodule

// File: rtl/chain_fifo_token.sv
module chain_fifo_token (
    input  logic clk,
    input  logic rst,
    input  logic own_at_reset,
    input  logic chained,
    input  logic take_n,
    input  logic pass,
    output logic own,
    output logic give_n
);
    logic own_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            own_q <= own_at_reset;
        end else if (!chained) begin
            own_q <= 1'b1;
        end else if (!take_n) begin
            own_q <= 1'b1;
        end else if (pass) begin
            own_q <= 1'b0;
        end
    end

    assign own    = own_q;
    assign give_n = !(chained && pass);
endmodule

// File: rtl/chain_fifo_store.sv
module chain_fifo_store
    import chain_fifo_pkg::*;
#(
    parameter int W     = 18,
    parameter int DEPTH = 256,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  side_t         go,
    input  logic [W-1:0]  wr_data,
    output logic [W-1:0]  rd_data,
    output logic          rd_fire,
    output logic [CW-1:0] level,
    output side_t         at_last
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] level_q;
    logic [W-1:0]  rd_data_q;
    logic          fire_q;

    always_ff @(posedge clk) begin
        if (go.wr) begin
            mem[wptr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr      <= '0;
            rptr      <= '0;
            level_q   <= '0;
            rd_data_q <= '0;
            fire_q    <= 1'b0;
        end else begin
            fire_q <= go.rd;
            if (go.wr) begin
                wptr <= AW'(ptr_step(32'(wptr), DEPTH));
            end
            if (go.rd) begin
                rd_data_q <= mem[rptr];
                rptr      <= AW'(ptr_step(32'(rptr), DEPTH));
            end
            case ({go.wr, go.rd})
                2'b10:   level_q <= level_q + 1'b1;
                2'b01:   level_q <= level_q - 1'b1;
                default: level_q <= level_q;
            endcase
        end
    end

    assign at_last.wr = (32'(wptr) == DEPTH - 1);
    assign at_last.rd = (32'(rptr) == DEPTH - 1);
    assign level      = level_q;
    assign rd_data    = rd_data_q;
    assign rd_fire    = fire_q;
endmodule

// File: rtl/chain_fifo_node.sv
module chain_fifo_node
    import chain_fifo_pkg::*;
#(
    parameter int W     = 18,
    parameter int DEPTH = 256
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         head_n,
    input  logic         wr_xi_n,
    input  logic         rd_xi_n,
    output logic         wr_xo_n,
    output logic         rd_xo_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         rd_fire,
    output logic         full,
    output logic         empty
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] LVL_FULL = CW'(DEPTH);
    localparam logic [CW-1:0] LVL_HALF = CW'(DEPTH / 2);

    node_mode_e    mode;
    logic          chained;
    logic          own_at_reset;
    logic [CW-1:0] level;
    side_t         go, at_last;
    logic [TOK_N-1:0] own, pass, take_n, give_n;
    logic          half;

    chain_fifo_mode u_mode (
        .clk     (clk),
        .rst     (rst),
        .wr_xi_n (wr_xi_n),
        .rd_xi_n (rd_xi_n),
        .mode    (mode)
    );

    assign chained      = (mode == MODE_CHAIN);
    assign own_at_reset = !head_n || (decode_mode(wr_xi_n, rd_xi_n) == MODE_SOLO);

    assign full  = (level == LVL_FULL);
    assign empty = (level == '0);
    assign half  = (level >= LVL_HALF);

    assign go.wr = wr_en && own[TOK_WR] && !full  && !rst;
    assign go.rd = rd_en && own[TOK_RD] && !empty && !rst;

    assign pass[TOK_WR]   = go.wr && at_last.wr;
    assign pass[TOK_RD]   = go.rd && at_last.rd;
    assign take_n[TOK_WR] = wr_xi_n;
    assign take_n[TOK_RD] = rd_xi_n;

    for (genvar gi = 0; gi < TOK_N; gi++) begin : g_tok
        chain_fifo_token u_tok (
            .clk          (clk),
            .rst          (rst),
            .own_at_reset (own_at_reset),
            .chained      (chained),
            .take_n       (take_n[gi]),
            .pass         (pass[gi]),
            .own          (own[gi]),
            .give_n       (give_n[gi])
        );
    end

    chain_fifo_store #(.W(W), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst     (rst),
        .go      (go),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .rd_fire (rd_fire),
        .level   (level),
        .at_last (at_last)
    );

    assign wr_xo_n = chained ? give_n[TOK_WR] : !half;
    assign rd_xo_n = chained ? give_n[TOK_RD] : 1'b1;
endmodule

// File: rtl/chain_fifo_chk.sv
module chain_fifo_chk #(
    parameter int DEPTH = 256,
    parameter int CW    = 9
) (
    input logic          clk,
    input logic          rst,
    input logic          chained,
    input logic          wr_own,
    input logic          rd_own,
    input logic          wr_xi_n,
    input logic          rd_xi_n,
    input logic          wr_xo_n,
    input logic          rd_xo_n,
    input logic [CW-1:0] level,
    input logic          full,
    input logic          empty
);
    // R9: occupancy bounded and flags exclusive
    a_r9_level_bound: assert property (@(posedge clk) disable iff (rst)
        (32'(level) <= DEPTH) && !(full && empty));

    // R4: without the write token the level never grows
    a_r4_no_write_without_token: assert property (@(posedge clk) disable iff (rst)
        !wr_own |=> (level <= $past(level)));

    // R5: a write hand-off pulse drops the write token
    a_r5_wr_pass_drops_token: assert property (@(posedge clk) disable iff (rst)
        (chained && !wr_xo_n && wr_xi_n) |=> !wr_own);

    // R8: a read hand-off pulse drops the read token
    a_r8_rd_pass_drops_token: assert property (@(posedge clk) disable iff (rst)
        (chained && !rd_xo_n && rd_xi_n) |=> !rd_own);

    // R6: a sampled hand-off pulse grants the token
    a_r6_take_wr_token: assert property (@(posedge clk) disable iff (rst)
        (chained && !wr_xi_n) |=> wr_own);

    a_r6_take_rd_token: assert property (@(posedge clk) disable iff (rst)
        (chained && !rd_xi_n) |=> rd_own);

    // R2: stand-alone node always owns both tokens
    a_r2_solo_owns_tokens: assert property (@(posedge clk) disable iff (rst)
        !chained |=> (wr_own && rd_own));

    // R10: stand-alone read hand-off output stays idle
    a_r10_solo_rd_idle: assert property (@(posedge clk) disable iff (rst)
        !chained |-> rd_xo_n);
endmodule

bind chain_fifo_node chain_fifo_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .chained (chained),
    .wr_own  (own[0]),
    .rd_own  (own[1]),
    .wr_xi_n (wr_xi_n),
    .rd_xi_n (rd_xi_n),
    .wr_xo_n (wr_xo_n),
    .rd_xo_n (rd_xo_n),
    .level   (level),
    .full    (full),
    .empty   (empty)
);

// File: tb/tb_chain_fifo_node.sv
module tb_chain_fifo_node;
    localparam int W     = 8;
    localparam int DEPTH = 4;
    localparam int NODES = 3;
    localparam int CAP   = NODES * DEPTH;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = !clk;

    logic         c_we = 1'b0, c_re = 1'b0;
    logic [W-1:0] c_wd = '0;
    logic         s_we = 1'b0, s_re = 1'b0;
    logic [W-1:0] s_wd = '0;

    logic [NODES-1:0] wxo, rxo, fire, fl, em;
    logic [W-1:0]     rdat [NODES];
    logic             s_wxo, s_rxo, s_fire, s_full, s_empty;
    logic [W-1:0]     s_rdat;

    chain_fifo_node #(.W(W), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst), .head_n(1'b0),
        .wr_xi_n(wxo[2]), .rd_xi_n(rxo[2]), .wr_xo_n(wxo[0]), .rd_xo_n(rxo[0]),
        .wr_en(c_we), .wr_data(c_wd), .rd_en(c_re), .rd_data(rdat[0]),
        .rd_fire(fire[0]), .full(fl[0]), .empty(em[0]));

    chain_fifo_node #(.W(W), .DEPTH(DEPTH)) peer1 (
        .clk(clk), .rst(rst), .head_n(1'b1),
        .wr_xi_n(wxo[0]), .rd_xi_n(rxo[0]), .wr_xo_n(wxo[1]), .rd_xo_n(rxo[1]),
        .wr_en(c_we), .wr_data(c_wd), .rd_en(c_re), .rd_data(rdat[1]),
        .rd_fire(fire[1]), .full(fl[1]), .empty(em[1]));

    chain_fifo_node #(.W(W), .DEPTH(DEPTH)) peer2 (
        .clk(clk), .rst(rst), .head_n(1'b1),
        .wr_xi_n(wxo[1]), .rd_xi_n(rxo[1]), .wr_xo_n(wxo[2]), .rd_xo_n(rxo[2]),
        .wr_en(c_we), .wr_data(c_wd), .rd_en(c_re), .rd_data(rdat[2]),
        .rd_fire(fire[2]), .full(fl[2]), .empty(em[2]));

    chain_fifo_node #(.W(W), .DEPTH(DEPTH)) solo (
        .clk(clk), .rst(rst), .head_n(1'b0),
        .wr_xi_n(1'b0), .rd_xi_n(1'b1), .wr_xo_n(s_wxo), .rd_xo_n(s_rxo),
        .wr_en(s_we), .wr_data(s_wd), .rd_en(s_re), .rd_data(s_rdat),
        .rd_fire(s_fire), .full(s_full), .empty(s_empty));

    int checks = 0;
    int fails  = 0;
    int model_count = 0;
    int exp_reads = 0;
    int got_reads = 0;
    logic [W-1:0] sb [$];
    logic [NODES-1:0] pre_w, pre_r;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // driver: one chain cycle, model updated from requirements R3/R7/R9/R11
    task automatic cyc(input bit we, input logic [W-1:0] wd, input bit re);
        bit acc_w, acc_r;
        @(negedge clk);
        c_we = we; c_wd = wd; c_re = re;
        #1;
        pre_w = wxo; pre_r = rxo;
        acc_w = we && (model_count < CAP);
        acc_r = re && (model_count > 0);
        if (acc_w) sb.push_back(wd);
        if (acc_r) exp_reads++;
        model_count = model_count + int'(acc_w) - int'(acc_r);
        @(posedge clk);
        #2;
        c_we = 1'b0; c_re = 1'b0;
    endtask

    // monitor: value and source node of every delivered word (R7, R11)
    always @(posedge clk) begin
        #1;
        if (!rst && fire != '0) begin
            chk($countones(fire) == 1, "R11 single source", int'(fire), 1);
            for (int n = 0; n < NODES; n++) begin
                if (fire[n]) begin
                    logic [W-1:0] e;
                    int src;
                    src = (got_reads / DEPTH) % NODES;
                    e = (sb.size() > 0) ? sb.pop_front() : '0;
                    chk(rdat[n] == e, "R7 read order", int'(rdat[n]), int'(e));
                    chk(n == src, "R11 read source node", n, src);
                end
            end
            got_reads++;
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk(wxo == '1 && rxo == '1, "R1 hand-off idle", int'({wxo, rxo}), 8'h3f);
        chk(em == '1 && fl == '0, "R1 flags after reset", int'({em, fl}), 8'h38);
        chk(fire == '0 && !s_fire, "R1 rd_fire low", int'(fire), 0);
        chk(s_wxo && s_rxo && s_empty, "R1 solo idle", int'({s_wxo, s_rxo, s_empty}), 7);

        // R3 head accepts, R4 peers ignore
        cyc(1'b1, 8'h10, 1'b0);
        chk(!em[0], "R3 head stores write", int'(em[0]), 0);
        chk(em[1] && em[2], "R4 non-owners ignore wr_en", int'(em[2:1]), 3);
        cyc(1'b0, '0, 1'b1);
        cyc(1'b0, '0, 1'b0);
        chk(em[0], "R7 head drained by read", int'(em[0]), 1);
        chk(rdat[1] == '0 && rdat[2] == '0, "R4 non-owners ignore rd_en",
            int'(rdat[1]) | int'(rdat[2]), 0);

        // R5 write hand-off at last location
        for (int k = 1; k <= 3; k++) begin
            cyc(1'b1, W'(8'h10 + k), 1'b0);
            if (k == 3) begin
                chk(pre_w[0] == 1'b0, "R5 write pulse at last location", int'(pre_w[0]), 0);
                chk(pre_w[1] == 1'b1, "R5 pulse only from owner", int'(pre_w[1]), 1);
            end else begin
                chk(pre_w[0] == 1'b1, "R5 no pulse before last location", int'(pre_w[0]), 1);
            end
        end
        // R6 next node took the token
        cyc(1'b1, 8'h14, 1'b0);
        chk(!em[1], "R6 next node accepts after hand-off", int'(em[1]), 0);
        chk(pre_w == '1, "R5 no pulse on ordinary write", int'(pre_w), 7);

        // R11 fill ring, wrap back to head
        for (int k = 5; k <= 12; k++) cyc(1'b1, W'(8'h10 + k), 1'b0);
        chk(fl == '1, "R11 ring full at N*DEPTH", int'(fl), 7);
        cyc(1'b1, 8'h1d, 1'b0);
        chk(fl == '1, "R9 write to full ring dropped", int'(fl), 7);

        // drain; R8 read pulse on head's last location
        for (int j = 0; j < 14; j++) begin
            cyc(1'b0, '0, 1'b1);
            if (j == 2)
                chk(pre_r[0] == 1'b0 && pre_r[1], "R8 read pulse at last location",
                    int'(pre_r), 6);
        end
        repeat (3) @(posedge clk);
        #1;
        chk(em == '1, "R9 all empty after drain", int'(em), 7);
        chk(got_reads == exp_reads, "R9 no read from empty", got_reads, exp_reads);

        // simultaneous write and read
        cyc(1'b1, 8'h30, 1'b1);
        cyc(1'b1, 8'h31, 1'b1);
        cyc(1'b0, '0, 1'b1);
        repeat (3) @(posedge clk);
        #1;
        chk(got_reads == exp_reads, "R7 read count with concurrent write", got_reads, exp_reads);
        chk(sb.size() == 0, "R3 every accepted word delivered", sb.size(), 0);

        // stand-alone node: R2, R10
        for (int k = 0; k < DEPTH; k++) begin
            @(negedge clk);
            s_we = 1'b1; s_wd = W'(8'h40 + k);
            @(posedge clk);
            #1;
            s_we = 1'b0;
            chk(s_wxo == ((k + 1) < DEPTH / 2), "R10 half flag", int'(s_wxo),
                int'((k + 1) < DEPTH / 2));
            chk(s_rxo == 1'b1, "R10 solo rd_xo_n idle", int'(s_rxo), 1);
        end
        chk(s_full, "R2 solo owns write token to full", int'(s_full), 1);
        for (int k = 0; k < DEPTH; k++) begin
            @(negedge clk);
            s_re = 1'b1;
            @(posedge clk);
            #1;
            s_re = 1'b0;
            chk(s_fire && s_rdat == W'(8'h40 + k), "R2 solo read order", int'(s_rdat),
                8'h40 + k);
        end
        chk(s_empty && s_wxo, "R10 solo below half when empty", int'({s_empty, s_wxo}), 3);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule